// File: doc/BRIEF.md
# Programmable Flag Offset Registers

This block keeps the two threshold offsets that a FIFO's almost-empty and almost-full flag logic compares against its fill level. A master reset loads both offsets with a default and, in the same cycle, fixes the programming method for the rest of operation. The default and the method both follow the level of one configuration input during that reset. A low level gives a small default and parallel programming. A high level gives a large default and bit-serial programming.

After reset, software or a controller updates the offsets through the permitted channel only. The parallel channel writes the two registers in turn through a shared pointer. The serial channel shifts a single data bit per clock into a frame that fills the almost-empty offset first and the almost-full offset second. The parallel read channel works in either method. The pin that carries serial data also selects the FIFO's read mode, but only while master reset is held. That mode is latched and brought out for the neighbouring read logic.

A partial reset restarts the pointer, the serial position and the read register. It keeps the offsets, the programming method and the read mode. Both resets are active low and are sampled on the clock edge. Master reset wins when both are low.

Top module: `flag_offset_regs`

## Requirements
- R1: A clock edge with `mrst_n` low and `cfg_sel` low sets both offsets to 127 (0x07F), selects the parallel method, points the pointer at the almost-empty register and clears `rd_data`.
- R2: A clock edge with `mrst_n` low and `cfg_sel` high sets both offsets to 1023 (0x3FF) and selects the serial method.
- R3: The level of `mode_si` at a master-reset edge is latched onto `fwft_mode`. Partial reset and serial traffic on `mode_si` leave it unchanged.
- R4: In the parallel method, each `par_wr` edge writes `wr_data[OFS_W-1:0]` into the register under the pointer. The pointer starts at almost-empty, alternates almost-empty then almost-full, and the upper data bits are dropped.
- R5: In the parallel method, `ser_en` has no effect on either offset.
- R6: In the serial method, each edge with `ser_en` high stores `mode_si` at frame position k. Positions 0 to OFS_W-1 are almost-empty bits 0 upward. Positions OFS_W to 2*OFS_W-1 are almost-full bits 0 upward. After position 2*OFS_W-1 the next bit goes to position 0 again.
- R7: In the serial method, `par_wr` changes neither offset and does not move the pointer.
- R8: In either method, a `par_rd` edge loads `rd_data` with the register under the pointer, zero-extended to DATA_W, and then advances the pointer.
- R9: When an accepted `par_wr` and a `par_rd` share an edge, only the write happens. `rd_data` holds and the pointer advances once.
- R10: A partial reset (`prst_n` low, `mrst_n` high) keeps both offsets, the method and `fwft_mode`. It returns the pointer to almost-empty, the serial position to 0, and `rd_data` to zero.
- R11: When `mrst_n` and `prst_n` are both low, the master-reset behaviour applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write-side clock; all state changes on its rising edge |
| mrst_n | input | 1 | Master reset, active low, sampled on the clock edge |
| prst_n | input | 1 | Partial reset, active low, sampled on the clock edge |
| cfg_sel | input | 1 | Load select, sampled during master reset: 0 parallel/127, 1 serial/1023 |
| mode_si | input | 1 | Read-mode select during master reset, serial data bit afterwards |
| ser_en | input | 1 | Serial shift enable |
| par_wr | input | 1 | Parallel offset write strobe |
| par_rd | input | 1 | Parallel offset read strobe |
| wr_data | input | DATA_W | Parallel write data; the low OFS_W bits are used |
| rd_data | output | DATA_W | Registered parallel read data |
| ae_ofs | output | OFS_W | Almost-empty offset to the flag logic |
| af_ofs | output | OFS_W | Almost-full offset to the flag logic |
| fwft_mode | output | 1 | Read mode latched at master reset |

## Verification
The bench builds the block with OFS_W=10 and DATA_W=12. The 1023 default then fills every offset bit, so a stuck or dropped bit shows at once. A serial frame is only 20 clocks, so frame wrap-around and partial frames cut short by partial reset fit in a short run. The two spare data bits show that parallel writes drop the upper bits and that reads zero-extend.

// File: rtl/fo_pkg.sv
package fo_pkg;

  typedef enum logic {
    SEL_AE = 1'b0,
    SEL_AF = 1'b1
  } ofs_sel_e;

  // Offset loaded by master reset for a given load-select level.
  function automatic int unsigned default_offset(input logic load_sel);
    return load_sel ? 32'd1023 : 32'd127;
  endfunction

  // Serial frame position to target register: true for almost-full half.
  function automatic logic frame_in_af(input int unsigned pos, input int unsigned w);
    return pos >= w;
  endfunction

  // Serial frame position to bit index within its register.
  function automatic int unsigned frame_bit(input int unsigned pos, input int unsigned w);
    return (pos >= w) ? pos - w : pos;
  endfunction

endpackage

// File: rtl/fo_cfg_latch.sv
module fo_cfg_latch (
  input  logic clk,
  input  logic mrst_n,
  input  logic prst_n,
  input  logic cfg_sel,
  input  logic mode_si,
  output logic ser_method,
  output logic fwft_mode
);

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      ser_method <= cfg_sel;
      fwft_mode  <= mode_si;
    end
  end

  // R3 / R10: outside master reset the latched settings never move.
  assert_cfg_kept_R10: assert property (@(posedge clk) disable iff (!mrst_n)
    1'b1 |=> $stable(ser_method) && $stable(fwft_mode));

  assert_mode_latch_R3: assert property (@(posedge clk) disable iff (!prst_n)
    !mrst_n |=> fwft_mode == $past(mode_si));

endmodule

// File: rtl/fo_par_port.sv
module fo_par_port
  import fo_pkg::*;
#(
  parameter int OFS_W  = 13,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              mrst_n,
  input  logic              prst_n,
  input  logic              run,
  input  logic              ser_method,
  input  logic              par_wr,
  input  logic              par_rd,
  input  logic [OFS_W-1:0]  ae_q,
  input  logic [OFS_W-1:0]  af_q,
  output logic              wr_ae,
  output logic              wr_af,
  output logic [DATA_W-1:0] rd_data
);

  ofs_sel_e ptr;
  logic     wr_ok;
  logic     rd_ok;
  logic     step;
  logic [OFS_W-1:0] rd_pick;

  assign wr_ok   = run && par_wr && !ser_method;
  assign rd_ok   = run && par_rd && !wr_ok;
  assign step    = wr_ok || rd_ok;
  assign wr_ae   = wr_ok && (ptr == SEL_AE);
  assign wr_af   = wr_ok && (ptr == SEL_AF);
  assign rd_pick = (ptr == SEL_AF) ? af_q : ae_q;

  always_ff @(posedge clk) begin
    if (!mrst_n || !prst_n) begin
      ptr     <= SEL_AE;
      rd_data <= '0;
    end else begin
      if (step) ptr <= (ptr == SEL_AE) ? SEL_AF : SEL_AE;
      if (rd_ok) rd_data <= DATA_W'(rd_pick);
    end
  end

  // R8: each accepted access moves the pointer exactly one register.
  assert_ptr_step_R8: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
    step |=> ptr != $past(ptr));

  // R7: a refused write leaves the pointer where it was.
  assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
    (ser_method && par_wr && !par_rd) |=> $stable(ptr));

  // R9: a write sharing the edge with a read keeps the read data.
  assert_wr_over_rd_R9: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
    (wr_ok && par_rd) |=> $stable(rd_data));

endmodule

// File: rtl/fo_ser_port.sv
module fo_ser_port
  import fo_pkg::*;
#(
  parameter int OFS_W = 13,
  localparam int FRAME = 2 * OFS_W,
  localparam int CW    = $clog2(FRAME),
  localparam int IW    = $clog2(OFS_W)
) (
  input  logic          clk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          run,
  input  logic          ser_method,
  input  logic          ser_en,
  output logic          shift_ok,
  output logic          shift_af,
  output logic [IW-1:0] shift_idx
);

  localparam logic [CW-1:0] LAST = CW'(FRAME - 1);

  logic [CW-1:0] pos;
  logic          at_last;

  assign shift_ok  = run && ser_en && ser_method;
  assign at_last   = (pos == LAST);
  assign shift_af  = frame_in_af(32'(pos), OFS_W);
  assign shift_idx = IW'(frame_bit(32'(pos), OFS_W));

  always_ff @(posedge clk) begin
    if (!mrst_n || !prst_n) begin
      pos <= '0;
    end else if (shift_ok) begin
      pos <= at_last ? '0 : pos + 1'b1;
    end
  end

  // R6: the frame position wraps to zero after its last bit.
  assert_frame_wrap_R6: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
    (shift_ok && at_last) |=> pos == '0);

  // R5: the parallel method never advances the serial position.
  assert_no_shift_R5: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
    !ser_method |=> $stable(pos));

endmodule

// File: rtl/fo_store.sv
module fo_store
  import fo_pkg::*;
#(
  parameter int OFS_W = 13,
  localparam int IW = $clog2(OFS_W)
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic             prst_n,
  input  logic             cfg_sel,
  input  logic             wr_ae,
  input  logic             wr_af,
  input  logic [OFS_W-1:0] wr_val,
  input  logic             shift_ok,
  input  logic             shift_af,
  input  logic [IW-1:0]    shift_idx,
  input  logic             shift_bit,
  output logic [OFS_W-1:0] ae_q,
  output logic [OFS_W-1:0] af_q
);

  logic [OFS_W-1:0] dflt;

  assign dflt = OFS_W'(default_offset(cfg_sel));

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      ae_q <= dflt;
      af_q <= dflt;
    end else begin
      if (wr_ae) ae_q <= wr_val;
      if (wr_af) af_q <= wr_val;
      if (shift_ok) begin
        if (shift_af) af_q[shift_idx] <= shift_bit;
        else          ae_q[shift_idx] <= shift_bit;
      end
    end
  end

  // R1: low load select at master reset gives 127 in both registers.
  assert_dflt_low_R1: assert property (@(posedge clk) disable iff (!prst_n && mrst_n)
    (!mrst_n && !cfg_sel) |=> (ae_q == OFS_W'(127)) && (af_q == OFS_W'(127)));

  // R2: high load select at master reset gives 1023 in both registers.
  assert_dflt_high_R2: assert property (@(posedge clk) disable iff (!prst_n && mrst_n)
    (!mrst_n && cfg_sel) |=> (ae_q == OFS_W'(1023)) && (af_q == OFS_W'(1023)));

  // R10: partial reset alone keeps both offsets.
  assert_prst_keep_R10: assert property (@(posedge clk) disable iff (!mrst_n)
    !prst_n |=> $stable(ae_q) && $stable(af_q));

endmodule

// File: rtl/flag_offset_regs.sv
module flag_offset_regs
  import fo_pkg::*;
#(
  parameter int OFS_W  = 13,
  parameter int DATA_W = 18,
  localparam int IW = $clog2(OFS_W)
) (
  input  logic              clk,
  input  logic              mrst_n,
  input  logic              prst_n,
  input  logic              cfg_sel,
  input  logic              mode_si,
  input  logic              ser_en,
  input  logic              par_wr,
  input  logic              par_rd,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [OFS_W-1:0]  ae_ofs,
  output logic [OFS_W-1:0]  af_ofs,
  output logic              fwft_mode
);

  logic          run;
  logic          ser_method;
  logic          wr_ae;
  logic          wr_af;
  logic          shift_ok;
  logic          shift_af;
  logic [IW-1:0] shift_idx;

  assign run = mrst_n && prst_n;

  fo_cfg_latch u_cfg (
    .clk        (clk),
    .mrst_n     (mrst_n),
    .prst_n     (prst_n),
    .cfg_sel    (cfg_sel),
    .mode_si    (mode_si),
    .ser_method (ser_method),
    .fwft_mode  (fwft_mode)
  );

  fo_par_port #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_par (
    .clk        (clk),
    .mrst_n     (mrst_n),
    .prst_n     (prst_n),
    .run        (run),
    .ser_method (ser_method),
    .par_wr     (par_wr),
    .par_rd     (par_rd),
    .ae_q       (ae_ofs),
    .af_q       (af_ofs),
    .wr_ae      (wr_ae),
    .wr_af      (wr_af),
    .rd_data    (rd_data)
  );

  fo_ser_port #(.OFS_W(OFS_W)) u_ser (
    .clk        (clk),
    .mrst_n     (mrst_n),
    .prst_n     (prst_n),
    .run        (run),
    .ser_method (ser_method),
    .ser_en     (ser_en),
    .shift_ok   (shift_ok),
    .shift_af   (shift_af),
    .shift_idx  (shift_idx)
  );

  fo_store #(.OFS_W(OFS_W)) u_store (
    .clk        (clk),
    .mrst_n     (mrst_n),
    .prst_n     (prst_n),
    .cfg_sel    (cfg_sel),
    .wr_ae      (wr_ae),
    .wr_af      (wr_af),
    .wr_val     (wr_data[OFS_W-1:0]),
    .shift_ok   (shift_ok),
    .shift_af   (shift_af),
    .shift_idx  (shift_idx),
    .shift_bit  (mode_si),
    .ae_q       (ae_ofs),
    .af_q       (af_ofs)
  );

  // R5: serial traffic in the parallel method leaves the offsets alone.
  assert_ser_ignored_R5: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
    (!ser_method && ser_en && !par_wr) |=> $stable(ae_ofs) && $stable(af_ofs));

  // R7: parallel writes in the serial method leave the offsets alone.
  assert_par_ignored_R7: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
    (ser_method && par_wr && !ser_en) |=> $stable(ae_ofs) && $stable(af_ofs));

  // R11: master reset wins over a simultaneous partial reset.
  assert_mrst_wins_R11: assert property (@(posedge clk) disable iff (1'b0)
    (!mrst_n && !prst_n) |=> ser_method == $past(cfg_sel));

endmodule

// File: tb/test_flag_offset_regs.sv
module test_flag_offset_regs;

  localparam int CLK_PERIOD = 10;
  localparam int W  = 10;
  localparam int DW = 12;

  logic          clk = 1'b0;
  logic          mrst_n = 1'b1, prst_n = 1'b1, cfg_sel = 1'b0, mode_si = 1'b0;
  logic          ser_en = 1'b0, par_wr = 1'b0, par_rd = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [W-1:0]  ae_ofs, af_ofs;
  logic          fwft_mode;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flag_offset_regs #(.OFS_W(W), .DATA_W(DW)) i_flag_offset_regs (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .cfg_sel(cfg_sel),
    .mode_si(mode_si), .ser_en(ser_en), .par_wr(par_wr), .par_rd(par_rd),
    .wr_data(wr_data), .rd_data(rd_data), .ae_ofs(ae_ofs), .af_ofs(af_ofs),
    .fwft_mode(fwft_mode)
  );

  // op: 0 write, 1 read, 2 write+read, 3 serial bit data[0]
  // fields: op[45:44] data[43:32] exp_ae[31:22] exp_af[21:12] exp_rd[11:0]
  localparam logic [45:0] VEC [9] = '{
    {2'd0, 12'hC55, 10'h055, 10'h07F, 12'h000},
    {2'd0, 12'h2AA, 10'h055, 10'h2AA, 12'h000},
    {2'd1, 12'h000, 10'h055, 10'h2AA, 12'h055},
    {2'd1, 12'h000, 10'h055, 10'h2AA, 12'h2AA},
    {2'd3, 12'h001, 10'h055, 10'h2AA, 12'h2AA},
    {2'd2, 12'h3C3, 10'h3C3, 10'h2AA, 12'h2AA},
    {2'd1, 12'h000, 10'h3C3, 10'h2AA, 12'h2AA},
    {2'd1, 12'h000, 10'h3C3, 10'h2AA, 12'h3C3},
    {2'd0, 12'h001, 10'h3C3, 10'h001, 12'h3C3}
  };

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pwrite(input logic [DW-1:0] d);
    wr_data = d; par_wr = 1'b1; tick(); par_wr = 1'b0;
  endtask

  task automatic pread();
    par_rd = 1'b1; tick(); par_rd = 1'b0;
  endtask

  task automatic sbit(input logic b);
    mode_si = b; ser_en = 1'b1; tick(); ser_en = 1'b0;
  endtask

  task automatic sframe(input logic [W-1:0] a, input logic [W-1:0] f);
    for (int i = 0; i < 2*W; i++) sbit(i < W ? a[i] : f[i-W]);
  endtask

  task automatic mreset(input logic sel, input logic si);
    cfg_sel = sel; mode_si = si; mrst_n = 1'b0; tick(); mrst_n = 1'b1;
  endtask

  task automatic preset();
    prst_n = 1'b0; tick(); prst_n = 1'b1;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1 / R3: parallel-method defaults, read mode latched high
    mreset(1'b0, 1'b1);
    check("R1", "ae default", ae_ofs, 'h07F);
    check("R1", "af default", af_ofs, 'h07F);
    check("R1", "rd cleared", rd_data, 0);
    check("R3", "fwft latched", fwft_mode, 1);

    // vector walk, parallel method (R4 R5 R8 R9)
    for (int k = 0; k < 9; k++) begin
      logic [45:0] v;
      string tg;
      v = VEC[k];
      case (v[45:44])
        2'd0: begin tg = "R4"; pwrite(v[43:32]); end
        2'd1: begin tg = "R8"; pread(); end
        2'd2: begin tg = "R9"; wr_data = v[43:32]; par_wr = 1'b1; par_rd = 1'b1;
                    tick(); par_wr = 1'b0; par_rd = 1'b0; end
        default: begin tg = "R5"; sbit(v[32]); end
      endcase
      check(tg, $sformatf("vec%0d ae", k), ae_ofs, v[31:22]);
      check(tg, $sformatf("vec%0d af", k), af_ofs, v[21:12]);
      check(tg, $sformatf("vec%0d rd", k), rd_data, v[11:0]);
    end

    // R10: partial reset with pointer at almost-full
    pread();
    check("R8", "rd ae before prst", rd_data, 'h3C3);
    preset();
    check("R10", "ae kept", ae_ofs, 'h3C3);
    check("R10", "af kept", af_ofs, 'h001);
    check("R10", "rd cleared", rd_data, 0);
    check("R10", "fwft kept", fwft_mode, 1);
    pwrite('h111);
    check("R10", "ptr back to ae", ae_ofs, 'h111);
    check("R10", "af untouched", af_ofs, 'h001);

    // R2: serial-method defaults
    mreset(1'b1, 1'b0);
    check("R2", "ae default", ae_ofs, 'h3FF);
    check("R2", "af default", af_ofs, 'h3FF);
    check("R3", "fwft latched low", fwft_mode, 0);

    // R6: full serial frame
    sframe('h12D, 'h2F0);
    check("R6", "ae serial", ae_ofs, 'h12D);
    check("R6", "af serial", af_ofs, 'h2F0);
    check("R3", "fwft after serial", fwft_mode, 0);

    // R7: parallel write ignored, pointer unmoved; R8 reads still work
    pwrite('h000);
    check("R7", "ae unchanged", ae_ofs, 'h12D);
    check("R7", "af unchanged", af_ofs, 'h2F0);
    pread();
    check("R7", "ptr still ae", rd_data, 'h12D);
    pread();
    check("R8", "read af serial mode", rd_data, 'h2F0);

    // R10: partial frame, then partial reset restarts position
    sbit(1'b1); sbit(1'b1); sbit(1'b1);
    check("R6", "partial frame ae", ae_ofs, 'h12F);
    preset();
    sbit(1'b0);
    check("R10", "serial pos restart", ae_ofs, 'h12E);
    check("R10", "method kept", af_ofs, 'h2F0);

    // R6: wrap after a complete frame
    preset();
    sframe('h001, 'h002);
    check("R6", "frame ae", ae_ofs, 'h001);
    check("R6", "frame af", af_ofs, 'h002);
    sbit(1'b0);
    check("R6", "wrap to ae bit0", ae_ofs, 'h000);
    check("R6", "wrap af kept", af_ofs, 'h002);

    // R11: both resets low -> master behaviour
    cfg_sel = 1'b0; mode_si = 1'b1; mrst_n = 1'b0; prst_n = 1'b0; tick();
    mrst_n = 1'b1; prst_n = 1'b1;
    check("R11", "ae default", ae_ofs, 'h07F);
    check("R11", "fwft relatched", fwft_mode, 1);
    pwrite('h055);
    check("R11", "parallel method", ae_ofs, 'h055);

    done = 1;
    summary();
    $finish;
  end

endmodule